// File: doc/BRIEF.md
# Separate-Port Double-Rate Burst SRAM

This block is an on-chip memory with one data bus for writing and another for reading. Both ports share a single address bus. Time is counted in edges of one fast data clock, and every two edges make up one core cycle. The first edge of a cycle is the read-address edge and the second is the write-address edge, so a read and a write can start in every cycle without contending for a bus. Each address holds a line of two words. Every access moves both words on consecutive edges, word 0 first, so data moves at double the core rate.

Each port has its own active-low select. When a port's select is high at that port's address edge, the port does nothing, which lets several instances share the address bus to build a deeper memory. Writes carry a byte-enable per word and commit to the storage without any handshake. A read always returns the newest data: if the write it follows has not yet reached the storage, the pending write data is merged in, byte by byte. A static mode input selects a read latency of one cycle or one and a half cycles.

Top module: `sp_burst_sram`

## Requirements
- R1: A read and a write may start in the same core cycle. The read result comes out on `rd_data` while the write data goes in on `wr_data`, and both take effect.
- R2: The first clock edge after reset is a read-address edge, and the edges then alternate between read-address and write-address. `rd_sel_n` and `addr` are sampled for a read only at read-address edges, and `wr_sel_n` and `addr` are sampled for a write only at write-address edges. A select level at the other kind of edge has no effect.
- R3: A write takes word 0 and its byte enables at its write-address edge, and word 1 at the following edge. A read delivers word 0 and then word 1 on two consecutive edges, with `rd_valid` high for both.
- R4: A port whose select is high at its address edge performs no access. A deselected read produces no valid word, and a deselected write leaves every stored line unchanged.
- R5: With `lat_long` low, word 0 of a read is visible after the second edge that follows the read-address edge, which is one core cycle.
- R6: With `lat_long` high, word 0 of a read is visible after the third edge that follows the read-address edge, which is one and a half core cycles. `lat_long` is held steady while reads are in flight.
- R7: A read whose address edge falls before a write's address edge in the same cycle returns the old data. A read that starts two or more cycles after the write returns the written data.
- R8: A read in the cycle right after a write to the same address returns the written data, taken from the pending write.
- R9: Bit l of `wr_be` enables byte lane l of the word that goes with it, where lane 0 is bits 7:0. Disabled lanes keep their previous contents, both in storage and in data that is forwarded from a pending write.
- R10: In reset, and on every edge that carries no read word, `rd_valid` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-rate clock; two edges make up one core cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_long | input | 1 | 0: one-cycle read latency, 1: one-and-a-half-cycle read latency |
| addr | input | ADDR_W | Shared address; read address at read edges, write address at write edges |
| rd_sel_n | input | 1 | Active-low read select, sampled at read-address edges |
| wr_sel_n | input | 1 | Active-low write select, sampled at write-address edges |
| wr_data | input | LANES*LANE_W | Write word: word 0 at the write-address edge, word 1 at the next edge |
| wr_be | input | LANES | Byte enables for the write word on the same edge |
| rd_data | output | LANES*LANE_W | Read word, zero when idle |
| rd_valid | output | 1 | High while `rd_data` carries a read word |

## Verification
The bench builds the block with a 4-bit address, two 8-bit lanes and 16-bit words, so it can sweep every one of the 16 lines, and every one of the 16 byte-enable combinations across the two words of a line, in a few hundred cycles. With so few lines, each address can be written and then read in the same cycle, in the next cycle and two cycles later. This exercises the storage path and the forwarding path in both latency modes, with writes and reads issued back to back. The expected data comes from a line-level model that applies each write once its second word is known.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   // Which half of the core cycle the next clock edge belongs to.
   typedef enum logic {
      PH_RD = 1'b0,
      PH_WR = 1'b1
   } phase_e;

   // Read latency selection, as decoded from the mode input.
   typedef enum logic {
      LAT_ONE      = 1'b0,
      LAT_ONE_HALF = 1'b1
   } lat_e;

   function automatic phase_e next_phase(input phase_e p);
      return (p == PH_RD) ? PH_WR : PH_RD;
   endfunction
endpackage

// File: rtl/sbs_store.sv
module sbs_store
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int LINE_L = 2 * LANES,
   localparam int LINE_W = LINE_L * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LINE_W-1:0] wdata,
   input  logic [LINE_L-1:0] wbe,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LINE_W-1:0] rdata
);
   logic [LINE_W-1:0] mem [DEPTH];

   initial begin
      assert (DEPTH <= 4096) else $error("sbs_store: depth %0d too large", DEPTH);
   end

   // Lane-masked line write; one commit per core cycle at most.
   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LINE_L; l++) begin
            if (wbe[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
         end
      end
   end

   // Asynchronous read; the read port registers the merged result.
   assign rdata = mem[raddr];
endmodule

// File: rtl/sbs_write_port.sv
module sbs_write_port
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int WORD_W = LANES * LANE_W,
   localparam int LINE_W = 2 * WORD_W,
   localparam int LINE_L = 2 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_be,
   output logic              pend_v,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [LINE_W-1:0] pend_data,
   output logic [LINE_L-1:0] pend_be
);
   logic              w_act;
   logic [ADDR_W-1:0] w_addr;
   logic [WORD_W-1:0] w_d0, w_d1;
   logic [LANES-1:0]  w_b0, w_b1;

   // Write-address edge: capture address and word 0, and retire the previous
   // slot, which the top commits on this same edge. The next edge adds word 1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_act  <= 1'b0;
         w_addr <= '0;
         w_d0   <= '0;
         w_d1   <= '0;
         w_b0   <= '0;
         w_b1   <= '0;
      end else if (ph == PH_WR) begin
         w_act <= !wr_sel_n;
         if (!wr_sel_n) begin
            w_addr <= addr;
            w_d0   <= wr_data;
            w_b0   <= wr_be;
         end
      end else if (w_act) begin
         w_d1 <= wr_data;
         w_b1 <= wr_be;
      end
   end

   assign pend_v    = w_act;
   assign pend_addr = w_addr;
   assign pend_data = {w_d1, w_d0};
   assign pend_be   = {w_b1, w_b0};

   // R2
   wr_slot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RD) |=> $stable(w_act) && $stable(w_addr));

   // R4
   wr_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WR && wr_sel_n) |=> !pend_v);
endmodule

// File: rtl/sbs_read_port.sv
module sbs_read_port
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int WORD_W = LANES * LANE_W,
   localparam int LINE_W = 2 * WORD_W,
   localparam int LINE_L = 2 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  logic              lat_long,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LINE_W-1:0] arr_data,
   input  logic              fwd_v,
   input  logic [ADDR_W-1:0] fwd_addr,
   input  logic [LINE_W-1:0] fwd_data,
   input  logic [LINE_L-1:0] fwd_be,
   output logic [ADDR_W-1:0] ra,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);
   lat_e              lat;
   logic              r_act, f_act, g_act;
   logic [LINE_W-1:0] merged, fbuf, gbuf;
   logic              fwd_hit;
   logic              o_v;
   logic [WORD_W-1:0] o_word, o_d;

   assign lat     = lat_e'(lat_long);
   assign fwd_hit = fwd_v && (fwd_addr == ra);

   // Per-lane coherency merge: enabled lanes of a pending write override storage.
   for (genvar l = 0; l < LINE_L; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = (fwd_hit && fwd_be[l])
         ? fwd_data[l*LANE_W +: LANE_W] : arr_data[l*LANE_W +: LANE_W];
   end

   // Pick the word for the next edge from the staging buffers.
   always_comb begin
      o_v    = 1'b0;
      o_word = '0;
      unique case ({lat, ph})
         {LAT_ONE, PH_RD}: begin
            o_v    = f_act;
            o_word = fbuf[WORD_W-1:0];
         end
         {LAT_ONE, PH_WR}: begin
            o_v    = g_act;
            o_word = gbuf[LINE_W-1:WORD_W];
         end
         {LAT_ONE_HALF, PH_WR}: begin
            o_v    = g_act;
            o_word = gbuf[WORD_W-1:0];
         end
         default: begin
            o_v    = g_act;
            o_word = gbuf[LINE_W-1:WORD_W];
         end
      endcase
      o_d = o_v ? o_word : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra       <= '0;
         r_act    <= 1'b0;
         fbuf     <= '0;
         f_act    <= 1'b0;
         gbuf     <= '0;
         g_act    <= 1'b0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (ph == PH_RD) begin
            r_act <= !rd_sel_n;
            if (!rd_sel_n) ra <= addr;
            gbuf  <= fbuf;
            g_act <= f_act;
         end else begin
            fbuf  <= merged;
            f_act <= r_act;
         end
         rd_data  <= o_d;
         rd_valid <= o_v;
      end
   end

   // R2
   rd_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WR) |=> $stable(ra));

   // R10
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   // R5
   rd_lat_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_valid) && !lat_long) |-> (ph == PH_WR));

   // R6
   rd_lat_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_valid) && lat_long) |-> (ph == PH_RD));

   // R3
   rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (ph == (lat_long ? PH_RD : PH_WR))) |=> rd_valid);
endmodule

// File: rtl/sp_burst_sram.sv
module sp_burst_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int WORD_W = LANES * LANE_W,
   localparam int LINE_W = 2 * WORD_W,
   localparam int LINE_L = 2 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lat_long,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_sel_n,
   input  logic              wr_sel_n,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_be,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 12) else $error("sp_burst_sram: ADDR_W %0d out of range", ADDR_W);
      assert (LANES >= 1) else $error("sp_burst_sram: LANES must be positive");
      assert (LANE_W >= 1) else $error("sp_burst_sram: LANE_W must be positive");
   end

   phase_e            ph;
   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr, ra;
   logic [LINE_W-1:0] pend_data, arr_data;
   logic [LINE_L-1:0] pend_be;
   logic              st_we;

   // Half-cycle phase: the first edge out of reset is a read-address edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_RD;
      else        ph <= next_phase(ph);
   end

   sbs_write_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph        (ph),
      .wr_sel_n  (wr_sel_n),
      .addr      (addr),
      .wr_data   (wr_data),
      .wr_be     (wr_be),
      .pend_v    (pend_v),
      .pend_addr (pend_addr),
      .pend_data (pend_data),
      .pend_be   (pend_be)
   );

   // A complete pending line retires on the next write-address edge.
   assign st_we = pend_v && (ph == PH_WR);

   sbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk   (clk),
      .we    (st_we),
      .waddr (pend_addr),
      .wdata (pend_data),
      .wbe   (pend_be),
      .raddr (ra),
      .rdata (arr_data)
   );

   sbs_read_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .lat_long (lat_long),
      .rd_sel_n (rd_sel_n),
      .addr     (addr),
      .arr_data (arr_data),
      .fwd_v    (pend_v),
      .fwd_addr (pend_addr),
      .fwd_data (pend_data),
      .fwd_be   (pend_be),
      .ra       (ra),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   // R2
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ph != $past(ph)));
endmodule

// File: tb/sp_burst_sram_test.sv
module sp_burst_sram_test;
   localparam int AW = 4, LN = 2, LW = 8, W = LN * LW, DEPTH = 1 << AW, MAXE = 4096;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0, lat_long = 1'b0, rd_sel_n = 1'b1, wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wr_data = '0, rd_data;
   logic [LN-1:0] wr_be = '0;
   logic          rd_valid;

   sp_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .addr(addr),
      .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wr_data(wr_data), .wr_be(wr_be),
      .rd_data(rd_data), .rd_valid(rd_valid));

   logic [W-1:0]  ref0 [DEPTH];
   logic [W-1:0]  ref1 [DEPTH];
   logic          exp_v [MAXE];
   logic [W-1:0]  exp_d [MAXE];
   int            e = 0, total = 0, bad = 0;
   string         req = "R10";
   logic          pend = 1'b0;
   logic [AW-1:0] pa;
   logic [W-1:0]  pd0, pd1;
   logic [LN-1:0] pb0, pb1;

   function automatic logic [W-1:0] mrg(input logic [W-1:0] o, input logic [W-1:0] n, input logic [LN-1:0] be);
      logic [W-1:0] r = o;
      for (int l = 0; l < LN; l++) if (be[l]) r[l*LW +: LW] = n[l*LW +: LW];
      return r;
   endfunction

   function automatic logic [W-1:0] pat(input int a, input int k, input int w);
      return W'((a * 16'h0123 + k * 16'h1111 + w * 16'h0f0f) ^ 16'h5a5a);
   endfunction

   task automatic check_edge();
      logic          ev = (e < MAXE) ? exp_v[e] : 1'b0;
      logic [W-1:0]  ed = (e < MAXE) ? exp_d[e] : '0;
      total++;
      if (rd_valid !== ev || rd_data !== ed) begin
         bad++;
         $display("FAIL %s edge %0d: valid=%b data=%h expected valid=%b data=%h", req, e, rd_valid, rd_data, ev, ed);
      end
   endtask

   // One core cycle: read-address edge, then write-address edge.
   task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                      input logic [W-1:0] d0, input logic [LN-1:0] b0,
                      input logic [W-1:0] d1, input logic [LN-1:0] b1);
      rd_sel_n = !rd;
      wr_sel_n = 1'b0;            // off-phase level, must be ignored (R2)
      addr     = ra;
      wr_data  = pend ? pd1 : ~pat(ra, 7, 7);
      wr_be    = pend ? pb1 : '1;
      @(posedge clk); #1;
      check_edge();
      if (pend) begin
         ref0[pa] = mrg(ref0[pa], pd0, pb0);
         ref1[pa] = mrg(ref1[pa], pd1, pb1);
         pend = 1'b0;
      end
      if (rd) begin
         int off = lat_long ? 3 : 2;
         exp_v[e+off] = 1'b1;   exp_d[e+off] = ref0[ra];
         exp_v[e+off+1] = 1'b1; exp_d[e+off+1] = ref1[ra];
      end
      e++;
      @(negedge clk);
      rd_sel_n = 1'b0;            // off-phase level, must be ignored (R2)
      wr_sel_n = !wr;
      addr     = wa;
      wr_data  = d0;
      wr_be    = b0;
      @(posedge clk); #1;
      check_edge();
      if (wr) begin
         pend = 1'b1; pa = wa; pd0 = d0; pb0 = b0; pd1 = d1; pb1 = b1;
      end
      e++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, '0, '0, '0, '0);
   endtask

   task automatic suite(input int k);
      // R2 / R3: fill every line with back-to-back writes
      req = lat_long ? "R2 R3 long" : "R2 R3";
      for (int a = 0; a < DEPTH; a++) cyc(0, '0, 1, AW'(a), pat(a, k, 0), '1, pat(a, k, 1), '1);
      // R1 with R5/R6: concurrent read and write each cycle
      req = lat_long ? "R1 R6" : "R1 R5";
      for (int a = 0; a < DEPTH; a++)
         cyc(1, AW'(a), 1, AW'(a ^ 8), pat(a, k, 2), '1, pat(a, k, 3), '1);
      for (int a = 0; a < DEPTH; a++) cyc(1, AW'(a), 0, '0, '0, '0, '0, '0);
      // R7 / R8: same-cycle, next-cycle and later reads of a fresh write
      req = lat_long ? "R7 R8 long" : "R7 R8";
      for (int a = 0; a < DEPTH; a++) begin
         cyc(0, '0, 1, AW'(a), pat(a, k, 4), '1, pat(a, k, 5), '1);
         cyc(1, AW'(a), 1, AW'(a), pat(a, k, 6), '1, pat(a, k, 7), '1);
         cyc(1, AW'(a), 0, '0, '0, '0, '0, '0);
         cyc(0, '0, 0, '0, '0, '0, '0, '0);
         cyc(1, AW'(a), 0, '0, '0, '0, '0, '0);
      end
      // R9: every enable combination across both words, forwarded and stored
      req = lat_long ? "R9 long" : "R9";
      for (int m = 0; m < 16; m++) begin
         cyc(0, '0, 1, AW'(m), pat(m, k, 8), LN'(m & 3), pat(m, k, 9), LN'(m >> 2));
         cyc(1, AW'(m), 0, '0, '0, '0, '0, '0);
         cyc(0, '0, 0, '0, '0, '0, '0, '0);
         cyc(1, AW'(m), 0, '0, '0, '0, '0, '0);
      end
      // R4 / R10: deselected ports, then read back unchanged lines
      req = lat_long ? "R4 R10 long" : "R4 R10";
      for (int a = 0; a < DEPTH; a++) cyc(0, AW'(a), 0, AW'(a), ~pat(a, k, 10), '1, ~pat(a, k, 11), '1);
      for (int a = 0; a < DEPTH; a++) cyc(1, AW'(a), 0, '0, '0, '0, '0, '0);
      idle(3);
   endtask

   initial begin
      for (int i = 0; i < MAXE; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      total++;
      if (rd_valid !== 1'b0 || rd_data !== '0) begin
         bad++;
         $display("FAIL R10 reset: valid=%b data=%h expected valid=0 data=0", rd_valid, rd_data);
      end
      rst_n = 1'b1;
      suite(1);
      lat_long = 1'b1;            // pipeline drained by idle cycles
      suite(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule